// File: doc/BRIEF.md
# Strobe-Framed Serial Register Slave

This block is a small register file inside a board control device, reached by a host over three serial wires (clock, host-to-device data, device-to-host data) and an active-low strobe. The host clocks bits in MSB first on rising serial-clock edges. It then ends every transaction with a command cycle: it lowers the strobe, gives one clock pulse, and raises the strobe again. The level of the data line during that pulse selects the action. A high level commits the shifted data to the addressed register. A low level copies the addressed register into an output shifter that drives the return line.

The register set holds boot-mode pin settings (29 bits), a multiplexer control word, a reset control register that raises a fixed-length reset request, a read-only version word, and a live view of an 8-bit switch port. The serial pins arrive asynchronously. Each one passes through a two-flop synchroniser, and the block finds the clock edges in the system clock domain.

Top module: `brd_ser_regs`

## Requirements
- R1: After reset, `miso_o` is 1 and `rst_req_o` is 0.
- R2: A write frame is 32 data bits MSB first, then 8 address bits MSB first, then a command cycle with MOSI at 1. The data lands in the addressed register.
- R3: A read frame is 8 address bits MSB first, then a command cycle with MOSI at 0. Bit 31 of the addressed value is on `miso_o` before the first read clock pulse, and each serial-clock falling edge (strobe high) moves on to the next lower bit. After 32 bits the line returns 1.
- R4: Address 0x00 holds a 29-bit mode field and reads back with bits 31..29 at 0. Address 0x02 holds a full 32-bit word.
- R5: Address 0xFF returns the `VERSION` parameter. Writes to it have no effect.
- R6: Address 0x01 returns `{24'b0, sw_i}`, sampled at the read command. Writes to it have no effect.
- R7: A read of any address other than 0x00, 0x01, 0x02, 0x80 and 0xFF returns 0xFFFFFFFF.
- R8: A write to address 0x80 with data bit 0 set raises `rst_req_o` on the third system-clock edge after the command pulse's rising edge reaches the pin. The output stays high for exactly 16 system clocks, and the register then reads 0.
- R9: A write to address 0x80 with data bit 0 clear stores the value and leaves `rst_req_o` low.
- R10: Only the last 8 bits shifted before a command form the address, and for a write only the 32 bits before them form the data. Earlier bits are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, asynchronous |
| mosi_i | input | 1 | Serial data from the host, asynchronous |
| stb_ni | input | 1 | Active-low command strobe, asynchronous |
| sw_i | input | 8 | Switch port shown at address 0x01 |
| miso_o | output | 1 | Serial data to the host |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
Each serial edge reaches the registers three system clocks after it appears at the pin: two synchroniser flops, then the edge-detect flop. A read value is therefore loaded into the output shifter three clocks after the command pulse rises, and each following bit appears three clocks after a falling edge. The bench holds every serial phase for six clocks, so it samples the return line only after the value has settled. For the reset pulse, the bench counts system clocks from the command edge to the rise of `rst_req_o` and expects exactly three. It then measures the width of the high phase and expects 16.

// File: rtl/brd_ser_pkg.sv
package brd_ser_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;
    localparam int unsigned MODE_W = 29;
    localparam int unsigned SW_W   = 8;

    localparam logic [ADDR_W-1:0] ADR_MODE = 8'h00;
    localparam logic [ADDR_W-1:0] ADR_SW   = 8'h01;
    localparam logic [ADDR_W-1:0] ADR_MUX  = 8'h02;
    localparam logic [ADDR_W-1:0] ADR_RST  = 8'h80;
    localparam logic [ADDR_W-1:0] ADR_VER  = 8'hFF;
endpackage

// File: rtl/brd_ser_pin_sync.sv
module brd_ser_pin_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic lvl_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int unsigned CHAIN_W = STAGES + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], pin_i};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {CHAIN_W{RST_VAL}};
        else         chain_q <= chain_d;
    end

    // chain_q[STAGES-1] is the synchronised level, chain_q[STAGES] its previous value
    assign lvl_o  = chain_q[STAGES-1];
    assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o = ~chain_q[STAGES-1] & chain_q[STAGES];
endmodule

// File: rtl/brd_ser_frame.sv
module brd_ser_frame
    import brd_ser_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              stb_lvl_i,
    input  logic              mosi_lvl_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              miso_o
);
    localparam int unsigned FRAME_W = DATA_W + ADDR_W;

    typedef struct packed {
        logic [FRAME_W-1:0] in_sr;
        logic [DATA_W-1:0]  out_sr;
    } frame_t;

    frame_t st_d, st_q;
    logic   wr_en;
    logic   cmd_edge;

    assign cmd_edge = rise_i & ~stb_lvl_i;

    always_comb begin
        st_d  = st_q;
        wr_en = 1'b0;
        if (rise_i) begin
            if (stb_lvl_i) begin
                st_d.in_sr = {st_q.in_sr[FRAME_W-2:0], mosi_lvl_i};
            end else if (mosi_lvl_i) begin
                wr_en = 1'b1;
            end else begin
                st_d.out_sr = rd_data_i;
            end
        end else if (fall_i && stb_lvl_i) begin
            st_d.out_sr = {st_q.out_sr[DATA_W-2:0], 1'b1};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.in_sr  <= '0;
            st_q.out_sr <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en_o   = wr_en;
    assign addr_o    = st_q.in_sr[ADDR_W-1:0];
    assign wr_data_o = st_q.in_sr[FRAME_W-1:ADDR_W];
    assign miso_o    = st_q.out_sr[DATA_W-1];

    // R10: a command edge must not disturb the captured frame
    a_r10_frame_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cmd_edge |=> $stable(addr_o) && $stable(wr_data_o));

    // R3: the return line only moves on a shift edge or a read load
    a_r3_miso_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fall_i && !cmd_edge) |=> $stable(miso_o));
endmodule

// File: rtl/brd_ser_bank.sv
module brd_ser_bank
    import brd_ser_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION   = 32'hB0A7_0103,
    parameter int unsigned       PULSE_CYC = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [SW_W-1:0]   sw_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rst_req_o
);
    localparam int unsigned CNT_W = $clog2(PULSE_CYC + 1);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [DATA_W-1:0] mux;
        logic [DATA_W-1:0] rst;
        logic              pulse;
        logic [CNT_W-1:0]  cnt;
    } bank_t;

    bank_t st_d, st_q;
    logic  start_pulse;

    assign start_pulse = wr_en_i && (addr_i == ADR_RST) && wr_data_i[0];

    always_comb begin
        st_d = st_q;
        if (st_q.pulse) begin
            if (st_q.cnt == CNT_W'(PULSE_CYC - 1)) begin
                st_d.pulse = 1'b0;
                st_d.rst   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (wr_en_i) begin
            unique case (addr_i)
                ADR_MODE: st_d.mode = wr_data_i[MODE_W-1:0];
                ADR_MUX:  st_d.mux  = wr_data_i;
                ADR_RST: begin
                    st_d.rst = wr_data_i;
                    if (wr_data_i[0]) begin
                        st_d.pulse = 1'b1;
                        st_d.cnt   = '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (addr_i)
            ADR_MODE: rd_data_o = {{(DATA_W-MODE_W){1'b0}}, st_q.mode};
            ADR_SW:   rd_data_o = {{(DATA_W-SW_W){1'b0}}, sw_i};
            ADR_MUX:  rd_data_o = st_q.mux;
            ADR_RST:  rd_data_o = st_q.rst;
            ADR_VER:  rd_data_o = VERSION;
            default:  rd_data_o = '1;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rst_req_o = st_q.pulse;

    // independent run-length counter for the pulse checks
    logic [CNT_W:0] run_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          run_q <= '0;
        else if (start_pulse) run_q <= '0;
        else if (rst_req_o)   run_q <= run_q + 1'b1;
        else                  run_q <= '0;
    end

    // R8: a pulse begins only after a reset write with bit 0 set
    a_r8_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_req_o) |-> $past(start_pulse));

    // R8: the pulse never exceeds its length
    a_r8_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> (run_q < (CNT_W+1)'(PULSE_CYC)));

    // R9: a reset write with bit 0 clear does not start a pulse
    a_r9_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == ADR_RST && !wr_data_i[0] && !rst_req_o) |=> !rst_req_o);
endmodule

// File: rtl/brd_ser_regs.sv
module brd_ser_regs
    import brd_ser_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION   = 32'hB0A7_0103,
    parameter int unsigned       PULSE_CYC = 16,
    parameter int unsigned       STAGES    = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            sck_i,
    input  logic            mosi_i,
    input  logic            stb_ni,
    input  logic [SW_W-1:0] sw_i,
    output logic            miso_o,
    output logic            rst_req_o
);
    localparam int unsigned NPIN = 3;
    localparam logic [NPIN-1:0] PIN_RST = 3'b100; // {strobe, mosi, sck} idle levels

    logic [NPIN-1:0] pins, lvl, rise, fall;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data, rd_data;

    assign pins = {stb_ni, mosi_i, sck_i};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        brd_ser_pin_sync #(.STAGES(STAGES), .RST_VAL(PIN_RST[g])) u_sync (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .pin_i (pins[g]),
            .lvl_o (lvl[g]),
            .rise_o(rise[g]),
            .fall_o(fall[g])
        );
    end

    brd_ser_frame u_frame (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_i    (rise[0]),
        .fall_i    (fall[0]),
        .stb_lvl_i (lvl[2]),
        .mosi_lvl_i(lvl[1]),
        .rd_data_i (rd_data),
        .wr_en_o   (wr_en),
        .addr_o    (addr),
        .wr_data_o (wr_data),
        .miso_o    (miso_o)
    );

    brd_ser_bank #(.VERSION(VERSION), .PULSE_CYC(PULSE_CYC)) u_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en),
        .addr_i   (addr),
        .wr_data_i(wr_data),
        .sw_i     (sw_i),
        .rd_data_o(rd_data),
        .rst_req_o(rst_req_o)
    );
endmodule

// File: tb/brd_ser_regs_tb_top.sv
module brd_ser_regs_tb_top;
    localparam logic [31:0] VER  = 32'hB0A7_0103;
    localparam int          HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, mosi = 1'b0, stb_n = 1'b1;
    logic [7:0] sw = 8'h00;
    logic miso, rst_req;

    always #4 clk = ~clk; // 125 MHz

    brd_ser_regs #(.VERSION(VER)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi),
        .stb_ni(stb_n), .sw_i(sw), .miso_o(miso), .rst_req_o(rst_req)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;
    int cyc = 0, cmd_cyc = 0, rise_cyc = 0, hi_cnt = 0, last_width = 0, rises = 0;
    logic prev_req = 1'b0;
    logic [31:0] exp_q[$], act_q[$];
    string tag_q[$];

    always @(posedge clk) cyc++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // reset pulse monitor
    always @(negedge clk) begin
        if (rst_req && !prev_req) begin rise_cyc = cyc; rises++; hi_cnt = 0; end
        if (rst_req) hi_cnt++;
        if (!rst_req && prev_req) last_width = hi_cnt;
        prev_req = rst_req;
    end

    // scoreboard monitor
    initial forever begin
        @(negedge clk);
        while (act_q.size() > 0 && exp_q.size() > 0) begin
            logic [31:0] a, e;
            string t;
            a = act_q.pop_front(); e = exp_q.pop_front(); t = tag_q.pop_front();
            chk(a === e, t, a, e);
        end
    end

    task automatic waitp(); repeat (HALF) @(negedge clk); endtask

    task automatic sbit(input logic b);
        mosi = b; waitp(); sck = 1'b1; waitp(); sck = 1'b0;
    endtask

    task automatic cmd(input logic w);
        mosi = w; stb_n = 1'b0; waitp();
        sck = 1'b1; cmd_cyc = cyc; waitp();
        sck = 1'b0; waitp();
        stb_n = 1'b1; waitp();
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        for (int i = 31; i >= 0; i--) sbit(d[i]);
        for (int i = 7; i >= 0; i--) sbit(a[i]);
        cmd(1'b1);
    endtask

    task automatic host_read(input logic [7:0] a, input logic [31:0] e, input string tag);
        logic [31:0] v;
        for (int i = 7; i >= 0; i--) sbit(a[i]);
        cmd(1'b0);
        exp_q.push_back(e); tag_q.push_back(tag);
        for (int i = 31; i >= 0; i--) begin
            mosi = 1'b0; sck = 1'b1; waitp();
            v[i] = miso; sck = 1'b0; waitp();
        end
        act_q.push_back(v);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(miso === 1'b1, "R1 miso idle", {31'b0, miso}, 32'h1);
        chk(rst_req === 1'b0, "R1 rst_req idle", {31'b0, rst_req}, 32'h0);

        host_read(8'hFF, VER, "R5 version");
        host_write(8'h02, 32'hA5C3_1E7F);
        host_read(8'h02, 32'hA5C3_1E7F, "R2 mux write");
        // R3: one more pulse after 32 bits returns 1
        sck = 1'b1; waitp();
        chk(miso === 1'b1, "R3 fill after 32 bits", {31'b0, miso}, 32'h1);
        sck = 1'b0; waitp();
        host_write(8'h00, 32'hFFFF_FFFF);
        host_read(8'h00, 32'h1FFF_FFFF, "R4 mode width");
        host_write(8'h02, 32'h0000_0001);
        host_read(8'h02, 32'h0000_0001, "R4 mux lsb");
        host_read(8'h00, 32'h1FFF_FFFF, "R4 mode kept");
        host_write(8'hFF, 32'h0);
        host_read(8'hFF, VER, "R5 version write ignored");
        sw = 8'h5A;
        host_read(8'h01, 32'h0000_005A, "R6 switch");
        host_write(8'h01, 32'hFFFF_FFFF);
        sw = 8'hC3;
        host_read(8'h01, 32'h0000_00C3, "R6 switch write ignored");
        host_read(8'h40, 32'hFFFF_FFFF, "R7 unmapped 0x40");
        host_read(8'h03, 32'hFFFF_FFFF, "R7 unmapped 0x03");
        // R9
        host_write(8'h80, 32'h0000_0006);
        repeat (30) @(negedge clk);
        chk(rises == 0, "R9 no pulse", rises, 0);
        host_read(8'h80, 32'h0000_0006, "R9 stored");
        // R8
        host_write(8'h80, 32'h0000_0001);
        repeat (40) @(negedge clk);
        chk(rises == 1, "R8 pulse seen", rises, 1);
        chk(rise_cyc - cmd_cyc == 3, "R8 latency", rise_cyc - cmd_cyc, 3);
        chk(last_width == 16, "R8 width", last_width, 16);
        host_read(8'h80, 32'h0, "R8 cleared");
        // R10: extra leading bits are discarded
        for (int i = 7; i >= 0; i--) sbit(1'b1);
        host_write(8'h02, 32'h1234_5678);
        host_read(8'h02, 32'h1234_5678, "R10 write prefix");
        for (int i = 7; i >= 0; i--) sbit(i[0]);
        host_read(8'h02, 32'h1234_5678, "R10 read prefix");
        repeat (10) @(negedge clk);
        while (act_q.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule